// File: doc/BRIEF.md
# SMBus Bus-State Monitor with Timeouts

This block sits beside an SMBus controller and tracks whether the two-wire bus is in use. It synchronizes the SCL and SDA inputs, recognizes START and STOP conditions, and keeps a busy flag. When the bus goes quiet without a STOP, a free timeout can release the busy flag. The free timeout counts ticks from one of four external time bases, chosen by a two-bit field.

A second timer watches for SCL being held low for too long. It is held at a reload value while SCL is high. It counts millisecond ticks only while SCL is low, and when it runs out it reports a single timeout event.

An 8-bit configuration register is written and read over a plain register port. It holds the enable, slave-interrupt inhibit, timeout enables, time-base select and an SDA setup/hold extension flag. The extension flag is only stored and driven out. The busy flag appears in the register as a read-only bit. The slave-inhibit bit masks slave interrupt requests on their way to the controller's interrupt line.

Top module: `smb_bus_watch`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x00 and `busy`, `bus_free`, `scl_timeout` and `hold_ext_en` are 0.
- R2: A write stores `cfg_wdata` into the register: bit 7 enable, bit 6 slave inhibit, bit 4 hold extension, bit 3 SCL-low timeout enable, bit 2 free-timeout enable, bits 1:0 time-base select. Bit 5 reads back the busy flag, and writes to bit 5 are ignored.
- R3: While the enable bit is 0, no START is recognized and `busy` stays 0.
- R4: With enable set, SDA falling while SCL is high (after a two-flop synchronizer on each line) sets `busy`.
- R5: SDA rising while SCL is high is a STOP, and it clears `busy`.
- R6: With the free-timeout enable set, once SCL and SDA have both been high for 11 ticks of the selected time base, `bus_free` pulses high for one cycle and `busy` clears. After 10 ticks, `busy` is still set.
- R7: Select value 0, 1, 2 or 3 picks `tick_src[0]`, `[1]`, `[2]` or `[3]`. Ticks on the other inputs do not advance the free timeout.
- R8: The free-timeout count restarts whenever either line is low. No free timeout occurs while the free-timeout enable is 0.
- R9: With SCL-low timeout enabled, `scl_timeout` pulses for one cycle on the `low_reload`-th `ms_tick` counted while SCL is low. No further pulse follows until SCL has gone high and low again.
- R10: While SCL is high, the SCL-low counter is held at `low_reload`, and `ms_tick` pulses have no effect.
- R11: `irq_out` is `master_irq_req` OR (`slave_irq_req` AND NOT inhibit).
- R12: `hold_ext_en` follows configuration bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| scl_in | input | 1 | Raw SCL line |
| sda_in | input | 1 | Raw SDA line |
| tick_src | input | 4 | Candidate time-base ticks for the free timeout |
| ms_tick | input | 1 | Millisecond-rate tick for the SCL-low timer |
| low_reload | input | 16 | SCL-low timer reload value, in ms ticks |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data, busy in bit 5 |
| slave_irq_req | input | 1 | Slave-event interrupt request |
| master_irq_req | input | 1 | Master-event interrupt request |
| irq_out | output | 1 | Gated interrupt request |
| busy | output | 1 | Bus in use |
| bus_free | output | 1 | One-cycle free-timeout pulse |
| scl_timeout | output | 1 | One-cycle SCL-low timeout pulse |
| hold_ext_en | output | 1 | Stored SDA setup/hold extension flag |

## Verification
The free timeout is tried on each of the four time bases. In each run, ticks are first sent on a wrong input, then ten ticks on the right one, then an eleventh. This separates a wrong select decode, a count that is off by one, and a count that never ends. A bus that idles without a STOP, with SCL dipped low part-way through, shows whether the count restarts or merely pauses. The SCL-low timer is fed ticks while SCL is high, then while it is low, and then past expiry. This tells holding apart from counting, and a single event apart from repeated ones.

// File: rtl/smb_bus_watch.sv
`timescale 1ns/1ps
module smb_bus_watch #(
  parameter int FREE_TICKS = 10,
  parameter int LOW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [3:0]       tick_src,
  input  logic             ms_tick,
  input  logic [LOW_W-1:0] low_reload,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  input  logic             slave_irq_req,
  input  logic             master_irq_req,
  output logic             irq_out,
  output logic             busy,
  output logic             bus_free,
  output logic             scl_timeout,
  output logic             hold_ext_en
);
  localparam int FW = $clog2(FREE_TICKS + 2);
  localparam logic [FW-1:0] FREE_LAST = FW'(FREE_TICKS);
  localparam logic [FW-1:0] FREE_SAT  = FW'(FREE_TICKS + 1);

  logic en, inh, ext, tmo_en, free_en;
  logic [1:0] sel;
  logic unused_wbit;
  assign unused_wbit = cfg_wdata[5];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {en, inh, ext, tmo_en, free_en, sel} <= '0;
    else if (cfg_we) {en, inh, ext, tmo_en, free_en, sel} <= {cfg_wdata[7:6], cfg_wdata[4:0]};

  assign cfg_rdata   = {en, inh, busy, ext, tmo_en, free_en, sel};
  assign hold_ext_en = ext;
  assign irq_out     = master_irq_req | (slave_irq_req & ~inh);

  logic [1:0] scl_sy, sda_sy;
  logic scl_d, sda_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_d  <= scl_sy[1];
      sda_d  <= sda_sy[1];
    end

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire start_ev = en & scl_s & scl_d & sda_d & ~sda_s;
  wire stop_ev  = en & scl_s & scl_d & ~sda_d & sda_s;

  logic [FW-1:0] fcnt;
  wire sel_tick = tick_src[sel];
  wire free_run = en & free_en & scl_s & sda_s;
  wire free_ev  = free_run & sel_tick & (fcnt == FREE_LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fcnt <= '0;
    else if (!free_run) fcnt <= '0;
    else if (sel_tick && fcnt != FREE_SAT) fcnt <= fcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; bus_free <= 1'b0;
    end else begin
      bus_free <= free_ev;
      if (!en) busy <= 1'b0;
      else if (start_ev) busy <= 1'b1;
      else if (stop_ev || free_ev) busy <= 1'b0;
    end

  logic [LOW_W-1:0] lcnt;
  logic expired;
  wire low_run = en & tmo_en & ~scl_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lcnt <= '0; expired <= 1'b0; scl_timeout <= 1'b0;
    end else begin
      scl_timeout <= 1'b0;
      if (!low_run) begin
        lcnt <= low_reload; expired <= 1'b0;
      end else if (ms_tick && !expired) begin
        if (lcnt <= LOW_W'(1)) begin
          lcnt <= '0; expired <= 1'b1; scl_timeout <= 1'b1;
        end else lcnt <= lcnt - 1'b1;
      end
    end

  assert_busy_ro_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && en && !start_ev && !stop_ev && !free_ev) |=> busy == $past(busy));
  assert_idle_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);
  assert_free_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_free |=> !bus_free);
  assert_free_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_free |-> !busy);
  assert_tmo_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    scl_timeout |=> !scl_timeout);
  assert_tmo_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_timeout) |-> !$past(scl_s));
  assert_inhibit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (inh && !master_irq_req) |-> !irq_out);
endmodule

// File: tb/smb_bus_watch_test.sv
`timescale 1ns/1ps
module smb_bus_watch_test;
  logic clk = 0, rst_n = 0, scl = 1, sda = 1, ms_tick = 0, cfg_we = 0;
  logic slave_irq = 0, master_irq = 0;
  logic [3:0] tick_src = 0;
  logic [15:0] low_reload = 16'd5;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic irq_out, busy, bus_free, scl_timeout, hold_ext_en;
  int errors = 0, checks = 0;
  int exp_q[$];

  always #2 clk = ~clk;

  smb_bus_watch uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .tick_src(tick_src),
    .ms_tick(ms_tick), .low_reload(low_reload), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .slave_irq_req(slave_irq), .master_irq_req(master_irq),
    .irq_out(irq_out), .busy(busy), .bus_free(bus_free), .scl_timeout(scl_timeout),
    .hold_ext_en(hold_ext_en));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pop_event(int kind);
    string req = (kind == 0) ? "R6" : "R9";
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL %s: actual=event %0d expected=none", req, kind);
    end else begin
      int e = exp_q.pop_front();
      if (e != kind) begin
        errors++;
        $display("FAIL %s: actual=event %0d expected=event %0d", req, kind, e);
      end
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (bus_free) pop_event(0);
    if (scl_timeout) pop_event(1);
  end

  task automatic wr(logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic idle(int n); repeat (n) @(negedge clk); endtask
  task automatic tick(int i, int n);
    repeat (n) begin @(negedge clk); tick_src[i] = 1; @(negedge clk); tick_src[i] = 0; end
  endtask
  task automatic mtick(int n);
    repeat (n) begin @(negedge clk); ms_tick = 1; @(negedge clk); ms_tick = 0; end
  endtask
  task automatic line(logic c, logic d); scl = c; sda = d; idle(5); endtask
  task automatic start_then_idle_high();
    line(1, 0); line(0, 0); line(0, 1); line(1, 1);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1; idle(2);
    check("R1 cfg", cfg_rdata, 8'h00);
    check("R1 flags", {busy, bus_free, scl_timeout, hold_ext_en}, 4'b0000);

    wr(8'hFF);
    check("R2 readback busy RO", cfg_rdata, 8'hDF);
    check("R12 ext on", hold_ext_en, 1);
    wr(8'h2F);
    check("R2 readback", cfg_rdata, 8'h0F);
    check("R12 ext off", hold_ext_en, 0);
    wr(8'h00);

    line(1, 0);
    check("R3 disabled no start", busy, 0);
    line(1, 1);

    wr(8'h84);
    line(1, 0);
    check("R4 start sets busy", busy, 1);
    wr(8'hA4);
    check("R2 write to bit5 ignored", cfg_rdata, 8'hA4);
    line(0, 0); line(1, 0); line(1, 1);
    check("R5 stop clears busy", busy, 0);

    for (int s = 0; s < 4; s++) begin
      wr(8'h84 | 8'(s));
      start_then_idle_high();
      check("R4 busy before free", busy, 1);
      tick((s + 1) % 4, 12);
      check("R7 wrong source ignored", busy, 1);
      tick(s, 10);
      check("R6 not free at 10", busy, 1);
      exp_q.push_back(0);
      tick(s, 1); idle(3);
      check("R6 free after 11", busy, 0);
      check("R7 event seen", exp_q.size(), 0);
    end

    wr(8'h84);
    start_then_idle_high();
    tick(0, 6);
    line(0, 1); line(1, 1);
    tick(0, 10);
    check("R8 restart after low", busy, 1);
    exp_q.push_back(0);
    tick(0, 1); idle(3);
    check("R8 free after restart", busy, 0);

    wr(8'h80);
    start_then_idle_high();
    tick(0, 15);
    check("R8 free disabled", busy, 1);
    line(1, 0); line(1, 1);
    check("R5 stop after disabled free", busy, 0);

    wr(8'h88);
    line(1, 1);
    mtick(10);
    line(0, 1);
    mtick(4);
    check("R10 held while high", scl_timeout, 0);
    exp_q.push_back(1);
    mtick(1); idle(2);
    check("R9 timeout seen", exp_q.size(), 0);
    mtick(6); idle(2);
    check("R9 single pulse", scl_timeout, 0);
    line(1, 1); line(0, 1);
    mtick(4);
    exp_q.push_back(1);
    mtick(1); idle(2);
    check("R9 rearmed after high", exp_q.size(), 0);
    line(1, 1);

    wr(8'hC0);
    slave_irq = 1; master_irq = 0; idle(1);
    check("R11 slave masked", irq_out, 0);
    master_irq = 1; idle(1);
    check("R11 master passes", irq_out, 1);
    wr(8'h80); master_irq = 0; idle(1);
    check("R11 slave unmasked", irq_out, 1);
    slave_irq = 0; idle(3);
    check("R9 R6 no stray events", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule